// File: doc/BRIEF.md
# Serial Command Word Decoder

This block watches a single serial command line, sampled once per clock, and turns short command words on it into one-cycle strobes. While the decoder is idle, any sampled 1 is taken as the opening bit of a word and becomes its most significant bit. The next two samples are shifted in as the middle bit and then the least significant bit, whatever their values. The finished 3-bit word selects one of four strobes. Three of the strobes are active-high. The resynchronise strobe is active-low.

The block sits right behind the line that carries level-1 commands into a front-end controller. Its strobes drive the local trigger, resynchronisation, calibration-pulse and bunch-counter-zero logic. Malformed words are not checked for. Every word that starts with a 1 and has two more bits decodes to exactly one command. The decoder goes back to idle as soon as the last bit is taken. A new opening bit can therefore be accepted on the very next clock, so words may follow each other with no gap.

Top module: `serial_trig_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the decoder returns to idle and drops any partly received word. After that edge `trig_o`, `calib_o` and `bc0_o` are 0 and `resync_n_o` is 1.
- R2: While idle with `cmd_line` sampled 0, no strobe is active (`trig_o`, `calib_o`, `bc0_o` at 0, `resync_n_o` at 1).
- R3: If `cmd_line` is sampled as 1, b1, b0 at three consecutive rising edges starting from idle, the matching strobe is active for exactly the one clock cycle that follows the third edge.
- R4: Word 1,0,0 (MSB first) asserts `trig_o` high.
- R5: Word 1,0,1 drives `resync_n_o` low.
- R6: Word 1,1,0 asserts `calib_o` high.
- R7: Word 1,1,1 asserts `bc0_o` high.
- R8: At most one strobe is active in any cycle.
- R9: A 1 sampled in the second or third bit position is data, not a new opening bit. A 0 in those positions does not abandon the word.
- R10: An opening bit sampled at the edge right after a word's last bit starts a new word, so words spaced three clocks apart are each decoded.
- R11: A word interrupted by reset produces no strobe, either during reset or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_line | input | 1 | Serial command line, one bit per clock |
| trig_o | output | 1 | Trigger strobe, active high, one cycle |
| resync_n_o | output | 1 | Resynchronise strobe, active low, one cycle |
| calib_o | output | 1 | Calibration-pulse strobe, active high, one cycle |
| bc0_o | output | 1 | Bunch-counter-zero strobe, active high, one cycle |

## Verification
Every cycle, the assertions check that each strobe is preceded, three edges earlier, by the line pattern of its own word. They also check that strobes never overlap, that each pulse lasts a single cycle, and that the outputs are inactive right after reset. Other behaviour can only be shown by the bench's scenarios: that a valid word really produces its strobe and not silence, that data bits equal to 1 do not restart the word, that words sent with no gap are all decoded, and that a word cut off by reset leaves no trace. The scoreboard covers these by predicting the cycle and the identity of every strobe from the words it sends, and it requires silence in every other cycle.

// File: rtl/trigdec_pkg.sv
// Package: shared constants for the serial command word decoder.
// Assumes a word width of at least 3 bits: one opening bit plus a payload
// of two or more bits.
package trigdec_pkg;

    // Total bits in a command word, opening bit included.
    localparam int CODE_W = 3;

    // Payload bits that follow the opening bit.
    localparam int PAY_W = CODE_W - 1;

    // One command per payload value.
    localparam int NUM_CMDS = 1 << PAY_W;

    // Index of each command, equal to its payload value.
    localparam int CMD_TRIG   = 0;
    localparam int CMD_RESYNC = 1;
    localparam int CMD_CALIB  = 2;
    localparam int CMD_BC0    = 3;

    // Strobes whose inactive level is 1 (only resynchronise).
    localparam logic [NUM_CMDS-1:0] LOW_ACTIVE = NUM_CMDS'(1 << CMD_RESYNC);

    // Capture FSM states.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } cap_state_t;

endpackage

// File: rtl/trigdec_capture.sv
// Module: trigdec_capture
// Watches the serial line for an opening 1 while idle, then shifts in PAY_W
// further bits. In the cycle where the last payload bit is on the line it
// raises word_valid_o, and payload_o shows the full payload (last bit taken
// straight from the line). It then goes back to idle at that same edge.
// Assumes PAY_W >= 2 and a synchronous active-low reset.
module trigdec_capture
    import trigdec_pkg::*;
#(
    parameter int PAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             word_valid_o,
    output logic [PAY_W-1:0] payload_o
);

    localparam int CNT_W = (PAY_W > 2) ? $clog2(PAY_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PAY_W - 1);

    cap_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAY_W-1:0] shreg_q;
    logic             last_bit;

    // Purpose: flag the cycle in which the final payload bit is on the line.
    always_comb begin
        last_bit = (state_q == ST_SHIFT) && (cnt_q == LAST_CNT);
    end

    // Purpose: sequence idle/shift and count payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (line_i) begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: shift payload bits in MSB first while a word is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            shreg_q <= {shreg_q[PAY_W-2:0], line_i};
        end else begin
            shreg_q <= '0;
        end
    end

    // Purpose: present the completed payload with the live final bit.
    always_comb begin
        word_valid_o = last_bit;
        payload_o    = {shreg_q[PAY_W-2:0], line_i};
    end

endmodule

// File: rtl/trigdec_decode.sv
// Module: trigdec_decode
// Turns a valid payload into a one-hot command vector, with one bit per
// possible payload value. Purely combinational.
// Assumes NUM_CMDS equals 2**PAY_W.
module trigdec_decode #(
    parameter int PAY_W    = 2,
    parameter int NUM_CMDS = 1 << PAY_W
) (
    input  logic                valid_i,
    input  logic [PAY_W-1:0]    payload_i,
    output logic [NUM_CMDS-1:0] hit_o
);

    // Purpose: one comparator per command value.
    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmp
        always_comb begin
            hit_o[i] = valid_i && (payload_i == PAY_W'(i));
        end
    end

endmodule

// File: rtl/trigdec_strobe.sv
// Module: trigdec_strobe
// Registers the command vector into the output strobes. Each bit's
// polarity comes from ACTIVE_LOW, and the inactive level is also the
// reset level. A strobe lasts one cycle because its input is a one-cycle
// hit. Assumes a synchronous active-low reset.
module trigdec_strobe #(
    parameter int                   NUM_CMDS   = 4,
    parameter logic [NUM_CMDS-1:0]  ACTIVE_LOW = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CMDS-1:0] hit_i,
    output logic [NUM_CMDS-1:0] strobe_o
);

    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_out
        // Purpose: register one strobe at its chosen polarity.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                strobe_o[i] <= ACTIVE_LOW[i];
            end else begin
                strobe_o[i] <= hit_i[i] ^ ACTIVE_LOW[i];
            end
        end
    end

endmodule

// File: rtl/serial_trig_decoder.sv
// Module: serial_trig_decoder (top)
// Decodes self-starting 3-bit serial command words into four one-cycle
// strobes: trigger, resynchronise (active low), calibration pulse and
// bunch-counter-zero. The strobe appears in the cycle after the word's
// last bit is sampled. Assumes the line is synchronous to clk.
module serial_trig_decoder
    import trigdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_line,
    output logic trig_o,
    output logic resync_n_o,
    output logic calib_o,
    output logic bc0_o
);

    logic                word_valid;
    logic [PAY_W-1:0]    payload;
    logic [NUM_CMDS-1:0] hit;
    logic [NUM_CMDS-1:0] strobe;

    trigdec_capture #(
        .PAY_W (PAY_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (cmd_line),
        .word_valid_o (word_valid),
        .payload_o    (payload)
    );

    trigdec_decode #(
        .PAY_W    (PAY_W),
        .NUM_CMDS (NUM_CMDS)
    ) u_decode (
        .valid_i   (word_valid),
        .payload_i (payload),
        .hit_o     (hit)
    );

    trigdec_strobe #(
        .NUM_CMDS   (NUM_CMDS),
        .ACTIVE_LOW (LOW_ACTIVE)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .strobe_o (strobe)
    );

    // Purpose: map the strobe vector onto the named outputs.
    always_comb begin
        trig_o     = strobe[CMD_TRIG];
        resync_n_o = strobe[CMD_RESYNC];
        calib_o    = strobe[CMD_CALIB];
        bc0_o      = strobe[CMD_BC0];
    end

endmodule

// File: rtl/serial_trig_decoder_chk.sv
// Module: serial_trig_decoder_chk
// Port-level properties for serial_trig_decoder, attached with bind.
module serial_trig_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_line,
    input logic trig_o,
    input logic resync_n_o,
    input logic calib_o,
    input logic bc0_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!trig_o && resync_n_o && !calib_o && !bc0_o));

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_o, !resync_n_o, calib_o, bc0_o}));

    // R4
    trig_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ($past(cmd_line, 3) && !$past(cmd_line, 2) && !$past(cmd_line, 1)));

    // R5
    resync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_n_o |-> ($past(cmd_line, 3) && !$past(cmd_line, 2) && $past(cmd_line, 1)));

    // R6
    calib_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calib_o |-> ($past(cmd_line, 3) && $past(cmd_line, 2) && !$past(cmd_line, 1)));

    // R7
    bc0_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc0_o |-> ($past(cmd_line, 3) && $past(cmd_line, 2) && $past(cmd_line, 1)));

    // R3
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o || !resync_n_o || calib_o || bc0_o) |=>
        (!trig_o && resync_n_o && !calib_o && !bc0_o));

endmodule

bind serial_trig_decoder serial_trig_decoder_chk u_chk (.*);

// File: tb/tb_serial_trig_decoder.sv
// Scoreboard bench: the driver sends words and queues the expected strobe
// with its cycle; the monitor compares on every falling edge.
module tb_serial_trig_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_line = 1'b0;
    logic trig_o, resync_n_o, calib_o, bc0_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int when;
        int idx;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    serial_trig_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_line   (cmd_line),
        .trig_o     (trig_o),
        .resync_n_o (resync_n_o),
        .calib_o    (calib_o),
        .bc0_o      (bc0_o)
    );

    function automatic string req_of(int idx);
        case (idx)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: opening 1, then b1, b0; strobe expected after 3 edges.
    task automatic send_word(input logic b1, input logic b0);
        exp_t e;
        @(negedge clk);
        cmd_line = 1'b1;
        e.when = cyc + 3;
        e.idx  = {b1, b0};
        expq.push_back(e);
        @(negedge clk);
        cmd_line = b1;
        @(negedge clk);
        cmd_line = b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_line = 1'b0;
        end
    endtask

    // Monitor: compare strobes against the scoreboard every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] obs;
            logic [3:0] exp_v;
            string rq;
            obs = {bc0_o, calib_o, !resync_n_o, trig_o};
            exp_v = 4'b0000;
            rq = "R2";
            if (expq.size() > 0 && expq[0].when == cyc) begin
                exp_v = 4'(1 << expq[0].idx);
                rq = req_of(expq[0].idx);
                void'(expq.pop_front());
            end
            checks++;
            if (obs !== exp_v) begin
                errors++;
                $display("FAIL %s (R3 timing, R8): cycle %0d strobes %b expected %b",
                         rq, cyc, obs, exp_v);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs inactive while in reset
        checks++;
        if ({trig_o, resync_n_o, calib_o, bc0_o} !== 4'b0100) begin
            errors++;
            $display("FAIL R1: outputs %b expected 0100",
                     {trig_o, resync_n_o, calib_o, bc0_o});
        end
        rst_n = 1'b1;
        idle(5);                    // R2: quiet idle
        send_word(1'b0, 1'b0);      // R4 trigger
        idle(4);
        send_word(1'b0, 1'b1);      // R5 resync
        idle(4);
        send_word(1'b1, 1'b0);      // R6 calib
        idle(4);
        send_word(1'b1, 1'b1);      // R7 bc0, R9 data ones no restart
        idle(6);
        // R10: back-to-back words
        send_word(1'b1, 1'b1);
        send_word(1'b0, 1'b0);
        send_word(1'b0, 1'b1);
        send_word(1'b1, 1'b0);
        idle(5);
        // R9: zeros after opening bit keep the word
        send_word(1'b0, 1'b0);
        send_word(1'b1, 1'b1);
        idle(5);
        // R11: reset interrupts a word, nothing emitted
        @(negedge clk); cmd_line = 1'b1;
        @(negedge clk); cmd_line = 1'b1;
        @(negedge clk); cmd_line = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(6);
        send_word(1'b1, 1'b0);      // decoder works after reset
        idle(5);
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d strobes missing, expected 0", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule